// File: doc/BRIEF.md
# Cascaded Identifier Chain Reader

This block identifies an attached adaptor and the plug fitted into it. Both units carry their identifiers in parallel-load shift registers that are chained together: the plug's serial output feeds the adaptor's serial input, so one serial line carries the adaptor identifier first and the plug identifier after it. The reader pulls an active-low load line to capture every register at once. It then clocks the chain and samples the data line one bit at a time, most significant bit first.

The combined identifier is between one and four bytes long. The first adaptor byte and the first plug byte each say, through a prefix bit, whether a second byte follows. A byte that reads all ones means the unit is absent, because pull-ups hold an empty position high. The reader shifts only the bytes that the prefixes call for. It reports the adaptor identifier, the plug identifier, their length and presence flags, and a lid status bit taken from the top bit of the first adaptor byte. A one-cycle `done` pulse marks the end of each read. The shift clock period is set by the `HALF_DIV` parameter.

Top module: `idc_chain_reader`

## Requirements
- R1: After reset, `id_load_n` is 1, `id_sclk` is 0, `done` is 0, and all identifier outputs and flags are 0.
- R2: A `start` accepted in idle holds `id_load_n` at 0 for 2*HALF_DIV clock cycles with `id_sclk` at 0. Each bit then takes HALF_DIV cycles with `id_sclk` at 0, followed by HALF_DIV cycles with `id_sclk` at 1. `id_sdata` is sampled at the end of the low half, most significant bit first, so the chain advances one position per rising edge of `id_sclk`.
- R3: A read that covers N bytes produces exactly 8*N rising edges of `id_sclk`. `done` is observed HALF_DIV*(2+16*N) cycles after the clock edge that accepts `start`. N is 1 when the adaptor is absent and otherwise runs from 2 to 4.
- R4: When the first adaptor byte is not 0xFF and its bit 6 is 1, the byte is a short adaptor identifier: `adp_present`=1, `adp_long`=0, and `adp_id` holds byte bits 5..0 zero-extended.
- R5: When the first adaptor byte has bit 6 at 0, the identifier is long: `adp_long`=1 and `adp_id` = {first byte bits 5..0, second byte}.
- R6: `lid_closed` equals bit 7 of the first adaptor byte when the adaptor is present, and is 0 when it is absent.
- R7: When the first plug byte is not 0xFF and its bit 7 is 1, the byte is a short plug identifier: `plg_present`=1, `plg_long`=0, and `plg_id` holds byte bits 6..0 zero-extended.
- R8: When the first plug byte has bit 7 at 0, the identifier is long: `plg_long`=1 and `plg_id` = {first plug byte bits 6..0, next byte}.
- R9: A first adaptor byte of 0xFF is checked before any format decoding. It reports `adp_present`=0 and `plg_present`=0, with every identifier, long flag and `lid_closed` at 0, and the read ends after that byte.
- R10: A first plug byte of 0xFF reports `plg_present`=0 with `plg_id`=0 and `plg_long`=0, and the read ends after that byte.
- R11: `done` is high for exactly one cycle per read. The outputs are valid in that cycle and stay unchanged until the next accepted `start`, which clears them.
- R12: `start` is ignored while a read is in progress. The running read keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read (accepted only when idle) |
| id_load_n | output | 1 | Active-low parallel load for the chain |
| id_sclk | output | 1 | Chain shift clock |
| id_sdata | input | 1 | Serial data from the chain |
| done | output | 1 | One-cycle completion pulse |
| adp_present | output | 1 | Adaptor detected |
| adp_long | output | 1 | Adaptor identifier is the 14-bit form |
| adp_id | output | 14 | Adaptor identifier |
| lid_closed | output | 1 | Lid status bit from the first adaptor byte |
| plg_present | output | 1 | Plug detected |
| plg_long | output | 1 | Plug identifier is the 15-bit form |
| plg_id | output | 15 | Plug identifier |

## Verification
The assertions assume that the chain returns a fresh byte after each load. They also assume that `id_sdata` changes only in response to `id_load_n` or a rising `id_sclk`, never between those events. The bench meets both conditions with a behavioural chain model that reloads on the falling load line and advances on each rising shift clock, and it feeds ones once the loaded bytes run out. Random identifiers are redrawn when a short form would read as 0xFF, so the absent encodings appear only in the directed cases that target R9 and R10.

// File: rtl/idc_pkg.sv
package idc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADP_W  = 14;
  localparam int PLG_W  = 15;

  typedef enum logic [1:0] {
    POS_ADP_HI, POS_ADP_LO, POS_PLG_HI, POS_PLG_LO
  } idc_pos_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD0, ST_LOAD1, ST_LOW, ST_HIGH, ST_DONE
  } idc_state_e;

  function automatic logic byte_absent(input logic [BYTE_W-1:0] b);
    return &b;
  endfunction

  function automatic logic adp_is_short(input logic [BYTE_W-1:0] b);
    return b[6];
  endfunction

  function automatic logic plg_is_short(input logic [BYTE_W-1:0] b);
    return b[7];
  endfunction

  // True when the byte at this position closes the read.
  function automatic logic byte_is_last(input idc_pos_e p, input logic [BYTE_W-1:0] b);
    case (p)
      POS_ADP_HI: return byte_absent(b);
      POS_ADP_LO: return 1'b0;
      POS_PLG_HI: return byte_absent(b) | plg_is_short(b);
      default:    return 1'b1;
    endcase
  endfunction

  function automatic idc_pos_e next_pos(input idc_pos_e p, input logic [BYTE_W-1:0] b);
    case (p)
      POS_ADP_HI: return adp_is_short(b) ? POS_PLG_HI : POS_ADP_LO;
      POS_ADP_LO: return POS_PLG_HI;
      default:    return POS_PLG_LO;
    endcase
  endfunction
endpackage

// File: rtl/idc_half_timer.sv
module idc_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/idc_bit_sequencer.sv
module idc_bit_sequencer
  import idc_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              id_sdata,
  input  logic              last_byte,
  output logic              start_acc,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              id_load_n,
  output logic              id_sclk,
  output logic              done,
  output logic              busy
);
  localparam int BCW = $clog2(BYTE_W + 1);
  localparam logic [BCW-1:0] FULL = BCW'(BYTE_W);

  idc_state_e      state;
  logic [BCW-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic            run, tick;

  assign run = (state == ST_LOAD0) || (state == ST_LOAD1) ||
               (state == ST_LOW)   || (state == ST_HIGH);

  idc_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  assign start_acc = (state == ST_IDLE) && start;
  assign byte_done = (state == ST_HIGH) && tick && (bitcnt == FULL);
  assign byte_val  = shreg;
  assign id_load_n = !((state == ST_LOAD0) || (state == ST_LOAD1));
  assign id_sclk   = (state == ST_HIGH);
  assign done      = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_LOAD0;
        ST_LOAD0: if (tick) state <= ST_LOAD1;
        ST_LOAD1: if (tick) begin
          state  <= ST_LOW;
          bitcnt <= '0;
        end
        ST_LOW: if (tick) begin
          shreg  <= {shreg[BYTE_W-2:0], id_sdata};
          bitcnt <= bitcnt + 1'b1;
          state  <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          if (bitcnt == FULL) begin
            bitcnt <= '0;
            state  <= last_byte ? ST_DONE : ST_LOW;
          end else begin
            state <= ST_LOW;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idc_field_decoder.sv
module idc_field_decoder
  import idc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              last_byte,
  output logic              adp_present,
  output logic              adp_long,
  output logic [ADP_W-1:0]  adp_id,
  output logic              lid_closed,
  output logic              plg_present,
  output logic              plg_long,
  output logic [PLG_W-1:0]  plg_id
);
  idc_pos_e pos;

  assign last_byte = byte_is_last(pos, byte_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= POS_ADP_HI;
      adp_present <= 1'b0; adp_long <= 1'b0; adp_id <= '0; lid_closed <= 1'b0;
      plg_present <= 1'b0; plg_long <= 1'b0; plg_id <= '0;
    end else if (clear) begin
      pos <= POS_ADP_HI;
      adp_present <= 1'b0; adp_long <= 1'b0; adp_id <= '0; lid_closed <= 1'b0;
      plg_present <= 1'b0; plg_long <= 1'b0; plg_id <= '0;
    end else if (byte_done) begin
      pos <= next_pos(pos, byte_val);
      case (pos)
        POS_ADP_HI: if (!byte_absent(byte_val)) begin
          adp_present <= 1'b1;
          lid_closed  <= byte_val[7];
          adp_long    <= !adp_is_short(byte_val);
          if (adp_is_short(byte_val)) adp_id <= ADP_W'(byte_val[5:0]);
          else                        adp_id <= {byte_val[5:0], 8'h00};
        end
        POS_ADP_LO: adp_id[7:0] <= byte_val;
        POS_PLG_HI: if (!byte_absent(byte_val)) begin
          plg_present <= 1'b1;
          plg_long    <= !plg_is_short(byte_val);
          if (plg_is_short(byte_val)) plg_id <= PLG_W'(byte_val[6:0]);
          else                        plg_id <= {byte_val[6:0], 8'h00};
        end
        default: plg_id[7:0] <= byte_val;
      endcase
    end
  end
endmodule

// File: rtl/idc_chain_reader.sv
module idc_chain_reader
  import idc_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             id_load_n,
  output logic             id_sclk,
  input  logic             id_sdata,
  output logic             done,
  output logic             adp_present,
  output logic             adp_long,
  output logic [ADP_W-1:0] adp_id,
  output logic             lid_closed,
  output logic             plg_present,
  output logic             plg_long,
  output logic [PLG_W-1:0] plg_id
);
  logic              start_acc, byte_done, last_byte, busy;
  logic [BYTE_W-1:0] byte_val;

  idc_bit_sequencer #(.HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .id_sdata(id_sdata),
    .last_byte(last_byte), .start_acc(start_acc), .byte_done(byte_done),
    .byte_val(byte_val), .id_load_n(id_load_n), .id_sclk(id_sclk),
    .done(done), .busy(busy)
  );

  idc_field_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .byte_done(byte_done),
    .byte_val(byte_val), .last_byte(last_byte),
    .adp_present(adp_present), .adp_long(adp_long), .adp_id(adp_id),
    .lid_closed(lid_closed), .plg_present(plg_present),
    .plg_long(plg_long), .plg_id(plg_id)
  );
endmodule

module idc_reader_checker
  import idc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             byte_done,
  input logic             id_load_n,
  input logic             id_sclk,
  input logic             done,
  input logic             adp_present,
  input logic             adp_long,
  input logic [ADP_W-1:0] adp_id,
  input logic             lid_closed,
  input logic             plg_present,
  input logic             plg_long,
  input logic [PLG_W-1:0] plg_id
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(adp_id) && $stable(plg_id) && $stable(adp_present)
                           && $stable(plg_present) && $stable(lid_closed)));

  assert_load_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !id_load_n |-> !id_sclk);

  assert_byte_at_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (id_sclk && id_load_n));

  assert_short_adp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && adp_present && !adp_long) |-> (adp_id[ADP_W-1:6] == '0));

  assert_short_plg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && plg_present && !plg_long) |-> (plg_id[PLG_W-1:7] == '0));

  assert_absent_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !adp_present) |-> (!plg_present && !lid_closed && !adp_long && adp_id == '0));

  assert_absent_plug_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !plg_present) |-> (!plg_long && plg_id == '0));
endmodule

bind idc_chain_reader idc_reader_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .byte_done(byte_done),
  .id_load_n(id_load_n), .id_sclk(id_sclk), .done(done),
  .adp_present(adp_present), .adp_long(adp_long), .adp_id(adp_id),
  .lid_closed(lid_closed), .plg_present(plg_present), .plg_long(plg_long),
  .plg_id(plg_id)
);

// File: tb/test_idc_chain_reader.sv
module test_idc_chain_reader;
  localparam int H = 4;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, id_sdata;
  logic id_load_n, id_sclk, done;
  logic adp_present, adp_long, lid_closed, plg_present, plg_long;
  logic [13:0] adp_id;
  logic [14:0] plg_id;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] chain = '1;
  int ptr = 0, sclk_rises = 0;

  // expected values
  logic e_ap, e_al, e_lid, e_pp, e_pl;
  logic [13:0] e_aid;
  logic [14:0] e_pid;
  int e_n;

  always #10 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  // behavioural chain: reload while load is low, advance on rising shift clock
  always @(negedge id_load_n) ptr <= 0;
  always @(posedge id_sclk) begin
    sclk_rises <= sclk_rises + 1;
    if (id_load_n) ptr <= ptr + 1;
  end
  assign id_sdata = (ptr < 32) ? chain[31 - ptr] : 1'b1;

  idc_chain_reader #(.HALF_DIV(H)) i_idc_chain_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .id_load_n(id_load_n),
    .id_sclk(id_sclk), .id_sdata(id_sdata), .done(done),
    .adp_present(adp_present), .adp_long(adp_long), .adp_id(adp_id),
    .lid_closed(lid_closed), .plg_present(plg_present), .plg_long(plg_long),
    .plg_id(plg_id)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // amode/pmode: 0 absent, 1 short, 2 long
  task automatic build(input int amode, input logic [13:0] aid, input logic lid,
                       input int pmode, input logic [14:0] pid);
    logic [7:0] bytes[4];
    int n = 0;
    e_ap = 0; e_al = 0; e_lid = 0; e_aid = '0; e_pp = 0; e_pl = 0; e_pid = '0;
    if (amode == 0) begin
      chain = '1; e_n = 1; return;
    end
    e_ap = 1; e_lid = lid;
    if (amode == 1) begin
      bytes[n++] = {lid, 1'b1, aid[5:0]}; e_aid = {8'h0, aid[5:0]};
    end else begin
      bytes[n++] = {lid, 1'b0, aid[13:8]}; bytes[n++] = aid[7:0];
      e_al = 1; e_aid = aid;
    end
    if (pmode == 0) bytes[n++] = 8'hFF;
    else if (pmode == 1) begin
      bytes[n++] = {1'b1, pid[6:0]}; e_pp = 1; e_pid = {8'h0, pid[6:0]};
    end else begin
      bytes[n++] = {1'b0, pid[14:8]}; bytes[n++] = pid[7:0];
      e_pp = 1; e_pl = 1; e_pid = pid;
    end
    chain = '1;
    for (int i = 0; i < n; i++) chain[31 - 8*i -: 8] = bytes[i];
    e_n = n;
  endtask

  task automatic run_read(input string tag, input bit poke);
    int m = 0, low = 0, r0;
    @(negedge clk); start = 1'b1;
    r0 = sclk_rises;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    while (!done && m < 2000) begin
      if (!id_load_n) low++;
      if (poke && m == 40) start = 1'b1;
      else start = 1'b0;
      @(negedge clk); m++;
    end
    start = 1'b0;
    chk(m == H*(2 + 16*e_n), {tag, " R3/R12 done time"}, m, H*(2 + 16*e_n));
    chk(low == 2*H, {tag, " R2 load width"}, low, 2*H);
    chk(sclk_rises - r0 == 8*e_n, {tag, " R3 shift edges"}, sclk_rises - r0, 8*e_n);
    chk(adp_present == e_ap && plg_present == e_pp, {tag, " R9/R10 presence"},
        {adp_present, plg_present}, {e_ap, e_pp});
    chk(adp_long == e_al && adp_id == e_aid, {tag, " R4/R5 adaptor id"},
        {adp_long, adp_id}, {e_al, e_aid});
    chk(lid_closed == e_lid, {tag, " R6 lid"}, lid_closed, e_lid);
    chk(plg_long == e_pl && plg_id == e_pid, {tag, " R7/R8 plug id"},
        {plg_long, plg_id}, {e_pl, e_pid});
    @(negedge clk);
    chk(!done, {tag, " R11 single pulse"}, done, 0);
    repeat (5) @(negedge clk);
    chk(adp_id == e_aid && plg_id == e_pid && adp_present == e_ap, {tag, " R11 hold"},
        {adp_id, plg_id}, {e_aid, e_pid});
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", WD_LIMIT, WD_LIMIT);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (3) @(negedge clk);
    chk(id_load_n && !id_sclk && !done, "R1 reset lines", {id_load_n, id_sclk, done}, 3'b100);
    chk(!adp_present && !plg_present && adp_id == 0 && plg_id == 0 && !lid_closed,
        "R1 reset outputs", {adp_present, plg_present, adp_id}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    build(0, 0, 0, 0, 0);             run_read("absent-adaptor R9", 0);
    build(1, 14'h15, 1, 0, 0);        run_read("plug-absent R10", 0);
    build(2, 14'h3FFF, 1, 2, 15'h7FFF); run_read("max-long R5 R8", 0);
    build(1, 14'h3E, 1, 1, 15'h7E);   run_read("short-short R4 R7", 0);
    build(2, 14'h0000, 0, 1, 15'h0);  run_read("long-zero R6", 0);
    build(1, 14'h2A, 0, 2, 15'h1234); run_read("busy-start R12", 1);

    for (int k = 0; k < 40; k++) begin
      int am = 1 + ($urandom % 2), pm = $urandom % 3;
      logic [13:0] a = 14'($urandom);
      logic [14:0] p = 15'($urandom);
      logic l = 1'($urandom);
      if (am == 1 && l && a[5:0] == 6'h3F) a[0] = 1'b0;
      if (pm == 1 && p[6:0] == 7'h7F) p[0] = 1'b0;
      build(am, a, l, pm, p);
      run_read("random", (k % 7) == 3);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule